// File: doc/BRIEF.md
# Programmed-I/O Byte FIFO

This block is the small byte queue that a host uses to move data one byte at a time to and from a bus controller without DMA. Each host write to the data register puts a byte on the queue, and each host read takes one off. The queue is a ring of sixteen bytes with a read index, a write index and an occupancy count. Both indexes go back to slot zero every time a read empties the queue.

A command-phase input sends host writes into a separate sixteen-byte command buffer, and the data queue is left alone. A bus-phase input tells whether the bus is moving data out or data in. While data is going out, reads consume occupancy but return zero. A status-load strobe replaces the queue contents with a two-byte response: the status byte, then 0x00. The block raises an interrupt request on every successful read and on every status load. The host clears it.

Top module: `pio_byte_fifo`

## Requirements
- R1: After reset, reg_rdata is 0x00, fifo_count is 0, irq is 0, overrun is 0, flags is 0x00 and cmd_len is 0.
- R2: A write strobe with reg_addr equal to 2, while cmd_phase is 0 and fifo_count is below 15, stores reg_wdata at the write index, advances the write index modulo 16 and adds one to fifo_count. A write to any other address changes nothing.
- R3: A write to address 2, while cmd_phase is 0 and fifo_count equals 15, is refused: fifo_count and the queue contents stay as they were, and overrun goes to 1. Overrun then stays 1 until reset.
- R4: While cmd_phase is 1, a write to address 2 stores the byte in command-buffer entry cmd_len and adds one to cmd_len, up to 16. Further writes are dropped, and the data queue is not touched. Entry i can be read on cmd_data when cmd_idx = i.
- R5: A read strobe at address 2 with fifo_count above 0 and bus_phase bits [2:1] not both zero (data-in) loads the entry at the read index into reg_rdata. It advances the read index, subtracts one from fifo_count and sets irq.
- R6: A read with fifo_count above 0 and bus_phase bits [2:1] equal to 00 (data-out) loads 0x00 into reg_rdata and leaves the read index where it is. It still subtracts one from fifo_count and sets irq.
- R7: A read while fifo_count is 0 leaves reg_rdata, irq and fifo_count unchanged.
- R8: When a read leaves fifo_count at 0, both indexes return to 0. The next byte written lands in slot 0 and is the next byte read.
- R9: A load_status pulse writes status_byte into slot 0 and 0x00 into slot 1. It sets fifo_count to 2, both indexes to 0 and flags to 0x02, and sets irq. In that cycle it overrides any register strobe, which has no effect.
- R10: irq_clr drops irq to 0 unless a read pop or a status load sets it in the same cycle, in which case the set wins.
- R11: reg_rdata is a register. It changes on the clock edge that samples the read strobe. If reg_wr and reg_rd are both high, only the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register offset; the data register is at 2 |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_wdata | input | 8 | Host write byte |
| reg_rdata | output | 8 | Latched data register value |
| cmd_phase | input | 1 | Sends writes to the command buffer |
| bus_phase | input | 3 | Bus phase; bits [2:1] = 00 means data-out |
| load_status | input | 1 | Loads the two-byte status response |
| status_byte | input | 8 | Status byte to load |
| irq_clr | input | 1 | Clears the interrupt request |
| irq | output | 1 | Interrupt request |
| overrun | output | 1 | Sticky overrun flag |
| fifo_count | output | 5 | Queue occupancy |
| flags | output | 8 | Flags register, written 2 by a status load |
| cmd_len | output | 5 | Number of bytes in the command buffer |
| cmd_idx | input | 4 | Command-buffer entry to view |
| cmd_data | output | 8 | Command-buffer entry at cmd_idx |

## Verification
The bench fills the queue to 15 and pushes once more. A design that accepted a sixteenth byte, or that let the overrun flag fall back, would drift from the reference model. Reads in the data-out phase check that zero comes back and that the read index holds; a design that advanced the index would return the wrong byte on the next data-in read. The indexes are walked around the 16-slot ring and also drained to zero, which exposes a design that forgets to snap the indexes back to zero. Status loads issued together with register strobes, and interrupt clears issued together with pops, test the priority rules.

// File: rtl/pio_byte_fifo.sv
module pio_byte_fifo #(
  parameter int DW        = 8,
  parameter int DEPTH     = 16,
  parameter int AW        = 4,
  parameter int DATA_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              cmd_phase,
  input  logic [2:0]        bus_phase,
  input  logic              load_status,
  input  logic [DW-1:0]     status_byte,
  input  logic              irq_clr,
  output logic              irq,
  output logic              overrun,
  output logic [$clog2(DEPTH):0]   fifo_count,
  output logic [DW-1:0]     flags,
  output logic [$clog2(DEPTH):0]   cmd_len,
  input  logic [$clog2(DEPTH)-1:0] cmd_idx,
  output logic [DW-1:0]     cmd_data
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] LIMIT = CW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL  = CW'(DEPTH);

  logic [DW-1:0] mem  [DEPTH];
  logic [DW-1:0] cbuf [DEPTH];
  logic [PW-1:0] rp, wp;

  wire hit      = reg_addr == AW'(DATA_ADDR);
  wire do_wr    = !load_status && reg_wr && hit;
  wire do_rd    = !load_status && !reg_wr && reg_rd && hit;
  wire push     = do_wr && !cmd_phase && fifo_count != LIMIT;
  wire refuse   = do_wr && !cmd_phase && fifo_count == LIMIT;
  wire cmd_push = do_wr && cmd_phase && cmd_len != FULL;
  wire pop      = do_rd && fifo_count != '0;
  wire data_out = bus_phase[2:1] == 2'b00;

  assign cmd_data = cbuf[cmd_idx];

  always_ff @(posedge clk) begin
    if (load_status) begin
      mem[0] <= status_byte;
      mem[1] <= '0;
    end else if (push) begin
      mem[wp] <= reg_wdata;
    end
    if (cmd_push) cbuf[cmd_len[PW-1:0]] <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp <= '0; wp <= '0; fifo_count <= '0; reg_rdata <= '0;
      flags <= '0; overrun <= 1'b0; cmd_len <= '0;
    end else if (load_status) begin
      rp <= '0; wp <= '0; fifo_count <= CW'(2); flags <= DW'(2);
    end else begin
      if (refuse) overrun <= 1'b1;
      if (cmd_push) cmd_len <= cmd_len + 1'b1;
      if (push) begin
        wp <= wp + 1'b1;
        fifo_count <= fifo_count + 1'b1;
      end
      if (pop) begin
        fifo_count <= fifo_count - 1'b1;
        reg_rdata  <= data_out ? '0 : mem[rp];
        if (fifo_count == CW'(1)) begin
          rp <= '0; wp <= '0;
        end else if (!data_out) begin
          rp <= rp + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  irq <= 1'b0;
    else if (load_status || pop) irq <= 1'b1;
    else if (irq_clr)            irq <= 1'b0;
  end

  // R3
  count_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= LIMIT);
  // R3
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R3
  refuse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && hit && !cmd_phase && !load_status && fifo_count == LIMIT)
      |=> (fifo_count == LIMIT && overrun));
  // R4
  cmd_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && hit && cmd_phase && !load_status) |=> $stable(fifo_count));
  // R6
  data_out_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && data_out) |=> reg_rdata == '0);
  // R8
  empty_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count == '0 |-> (rp == '0 && wp == '0));
  // R9
  status_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_status |=> (fifo_count == CW'(2) && irq && flags == DW'(2)));
endmodule

// File: tb/pio_byte_fifo_test.sv
`timescale 1ns/1ps
module pio_byte_fifo_test;
  logic clk = 0, rst_n = 0;
  logic [3:0] reg_addr = 2;
  logic reg_wr = 0, reg_rd = 0, cmd_phase = 0, load_status = 0, irq_clr = 0;
  logic [7:0] reg_wdata = 0, status_byte = 0;
  logic [2:0] bus_phase = 3'b001;
  logic [3:0] cmd_idx = 0;
  logic [7:0] reg_rdata, flags, cmd_data;
  logic irq, overrun;
  logic [4:0] fifo_count, cmd_len;

  always #2 clk = ~clk;

  pio_byte_fifo uut (.clk, .rst_n, .reg_addr, .reg_wr, .reg_rd, .reg_wdata,
    .reg_rdata, .cmd_phase, .bus_phase, .load_status, .status_byte, .irq_clr,
    .irq, .overrun, .fifo_count, .flags, .cmd_len, .cmd_idx, .cmd_data);

  int checks = 0, errors = 0;
  bit done = 0;
  int m_mem[16], m_cmd[16];
  int m_rp, m_wp, m_cnt, m_rd, m_irq, m_ovr, m_flags, m_clen;

  task automatic model_reset();
    m_rp = 0; m_wp = 0; m_cnt = 0; m_rd = 0; m_irq = 0; m_ovr = 0;
    m_flags = 0; m_clen = 0;
  endtask

  task automatic model_step();
    bit hit, pop;
    hit = reg_addr == 2;
    pop = 0;
    if (load_status) begin
      m_mem[0] = status_byte; m_mem[1] = 0; m_cnt = 2; m_rp = 0; m_wp = 0;
      m_flags = 2; m_irq = 1;
      return;
    end
    if (reg_wr && hit) begin
      if (cmd_phase) begin
        if (m_clen < 16) begin m_cmd[m_clen] = reg_wdata; m_clen++; end
      end else if (m_cnt == 15) m_ovr = 1;
      else begin m_mem[m_wp] = reg_wdata; m_wp = (m_wp + 1) % 16; m_cnt++; end
    end else if (reg_rd && hit && m_cnt > 0) begin
      pop = 1;
      m_cnt--;
      if (bus_phase[2:1] == 0) m_rd = 0;
      else begin m_rd = m_mem[m_rp]; m_rp = (m_rp + 1) % 16; end
      if (m_cnt == 0) begin m_rp = 0; m_wp = 0; end
    end
    if (pop) m_irq = 1;
    else if (irq_clr) m_irq = 0;
  endtask

  task automatic compare(string tag);
    checks++;
    if (reg_rdata !== 8'(m_rd) || fifo_count !== 5'(m_cnt) || irq !== 1'(m_irq) ||
        overrun !== 1'(m_ovr) || flags !== 8'(m_flags) || cmd_len !== 5'(m_clen) ||
        (cmd_idx < m_clen && cmd_data !== 8'(m_cmd[cmd_idx]))) begin
      errors++;
      $display("FAIL %s: got rdata=%h cnt=%0d irq=%b ovr=%b flags=%h clen=%0d cmd=%h exp rdata=%h cnt=%0d irq=%0d ovr=%0d flags=%h clen=%0d cmd=%h",
        tag, reg_rdata, fifo_count, irq, overrun, flags, cmd_len, cmd_data,
        m_rd, m_cnt, m_irq, m_ovr, m_flags, m_clen, m_cmd[cmd_idx]);
    end
  endtask

  task automatic step(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    reg_wr = 0; reg_rd = 0; load_status = 0; irq_clr = 0;
    compare(tag);
  endtask

  task automatic wr(string tag, input logic [7:0] d);
    reg_wr = 1; reg_wdata = d; step(tag);
  endtask

  task automatic rd(string tag);
    reg_rd = 1; step(tag);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare("R1");
    for (int i = 0; i < 5; i++) wr("R2", 8'h10 + 8'(i));
    reg_addr = 4'h5; wr("R2", 8'hEE); reg_rd = 1; step("R7");
    reg_addr = 4'h2;
    rd("R5"); rd("R5"); idle("R11");
    irq_clr = 1; step("R10");
    bus_phase = 3'b000; rd("R6");
    bus_phase = 3'b011; rd("R5");
    rd("R8");
    rd("R7"); rd("R7");
    wr("R8", 8'hA5); rd("R8");
    for (int i = 0; i < 15; i++) wr("R2", 8'h40 + 8'(i));
    wr("R3", 8'hFF); wr("R3", 8'hFE);
    for (int i = 0; i < 7; i++) rd("R5");
    for (int i = 0; i < 7; i++) wr("R2", 8'h80 + 8'(i));
    bus_phase = 3'b010;
    for (int i = 0; i < 15; i++) rd("R5");
    rd("R7");
    cmd_phase = 1;
    for (int i = 0; i < 17; i++) begin
      cmd_idx = 4'(i > 0 ? i - 1 : 0); wr("R4", 8'hC0 + 8'(i));
    end
    for (int i = 0; i < 16; i++) begin cmd_idx = 4'(i); idle("R4"); end
    cmd_phase = 0;
    wr("R2", 8'h33);
    status_byte = 8'h5A; load_status = 1; reg_wr = 1; reg_wdata = 8'h77; step("R9");
    irq_clr = 1; step("R10");
    rd("R9"); irq_clr = 1; reg_rd = 1; step("R10"); rd("R7");
    reg_wr = 1; reg_rd = 1; reg_wdata = 8'h9C; step("R11");
    rd("R11");
    rst_n = 0; model_reset(); m_ovr = 0;
    @(posedge clk); @(negedge clk); rst_n = 1; compare("R1");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic idle(string tag);
    step(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule